// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs a 10-bit successive-approximation conversion from start to finish. Software writes a GO request. The sequencer then keeps the sampling capacitor on the input for a programmable number of conversion-clock periods (TAD). It then isolates the capacitor and resolves one result bit per TAD, from the most significant bit down. A DAC is driven with a trial code, and an external comparator reports whether the input is at or above that code. A one-cycle `tad_tick` pulse paces every step.

When the last bit is resolved, one clock cycle does four things: it loads the result pair, drops GO, raises a sticky done flag and reconnects the capacitor. Software may cancel by clearing GO, and the result pair then keeps its earlier contents. After a finish or an abort, a fixed two-TAD recovery gap must pass before the next acquisition. A GO request written during that gap is held until the gap ends.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset `go_bit`=0, `sample_hold`=1, `dac_code`=0, `res_hi`=`res_lo`=0 and `done_flag`=0. An idle, enabled sequencer that sees `go_set` shows `go_bit`=1 from the next cycle until the conversion finishes or is aborted.
- R2: With `acq_code`=000 there is no acquisition phase: `sample_hold` is 0 in the cycle after the accepted `go_set`.
- R3: `acq_code` values 001 to 111 keep `sample_hold`=1 for 2, 4, 6, 8, 12, 16 and 20 TAD ticks after the request. `sample_hold` falls in the cycle after the last of those ticks.
- R4: During a conversion `sample_hold` is 0 for exactly 11 TAD ticks. The last of these ticks completes the conversion.
- R5: The first conversion tick puts 1 in bit 9 of `dac_code`. At each of the next ten ticks, the current trial bit is kept if `cmp_in`=1 (input ≥ DAC) and cleared if it is 0, and the next lower bit is set to 1. The tick that resolves bit 0 sets no further bit.
- R6: In the cycle after the completing tick, `res_hi`/`res_lo` hold the result, `go_bit`=0, `done_flag`=1 and `sample_hold`=1.
- R7: With `left_just`=0 the result is right-aligned: `res_hi` holds bits 9:8 in its bits 1:0 with zeros above, and `res_lo` holds bits 7:0. With `left_just`=1, `res_hi` holds bits 9:2 and `res_lo` holds bits 1:0 in its bits 7:6 with zeros below.
- R8: `go_clr` during acquisition or conversion aborts it: `go_bit` goes to 0, and `res_hi`, `res_lo` and `done_flag` are not changed. `go_clr` wins over a completing tick in the same cycle.
- R9: After a finish or an abort, no acquisition or conversion starts until 2 TAD ticks have passed. A `go_set` during that gap makes `go_bit`=1 and starts the sequence when the gap ends.
- R10: `done_flag` stays set until a `flag_clr` strobe. If a completion and `flag_clr` fall in the same cycle, the flag is set.
- R11: While `enable`=0 the sequencer returns to idle and `go_bit`=0. A `go_set` in the first cycle of `enable`=1 is ignored.
- R12: `res_wr` loads `res_wr_hi`/`res_wr_lo` into the result pair. A completion in the same cycle takes priority over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Module enable; when low, the sequencer is forced idle |
| tad_tick | input | 1 | One-cycle pulse per conversion clock period |
| go_set | input | 1 | Write strobe that sets GO (start request) |
| go_clr | input | 1 | Write strobe that clears GO (abort) |
| acq_code | input | 3 | Automatic acquisition length code |
| left_just | input | 1 | Result alignment: 1 = left, 0 = right |
| flag_clr | input | 1 | Clears the done flag |
| res_wr | input | 1 | Software write strobe for the result pair |
| res_wr_hi | input | 8 | Data for the high result register |
| res_wr_lo | input | 8 | Data for the low result register |
| cmp_in | input | 1 | Comparator: 1 when input ≥ DAC output |
| go_bit | output | 1 | GO/busy readback |
| sample_hold | output | 1 | 1 = capacitor tracks input, 0 = held |
| dac_code | output | 10 | Trial code for the DAC |
| res_hi | output | 8 | High result register |
| res_lo | output | 8 | Low result register |
| done_flag | output | 1 | Sticky completion flag |

## Verification
Several actions can land on the cycle whose tick resolves bit 0: the completion that sets the flag and loads the result, a software `flag_clr`, a software result write and a `go_clr` abort. The bench finds that cycle from its reference model, which knows the phase, the pending bit position and the next tick. It pulses the colliding strobe exactly there. It then expects the flag set and the conversion result loaded for clear-plus-write. For an abort on that tick, it expects the result and flag left as they were.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ACQ   = 2'd1,
    SEQ_CONV  = 2'd2,
    SEQ_RECOV = 2'd3
  } seq_state_t;

  localparam int unsigned ACQ_TAD_MAX = 20;

  // TAD periods of automatic acquisition for each 3-bit code
  function automatic int unsigned acq_tad_count(input logic [2:0] code);
    case (code)
      3'd0:    return 0;
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 6;
      3'd4:    return 8;
      3'd5:    return 12;
      3'd6:    return 16;
      default: return ACQ_TAD_MAX;
    endcase
  endfunction

endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int RES_W   = 10,
  parameter int REC_TAD = 2,
  parameter int CNT_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tad_tick,
  input  logic             go_set,
  input  logic             go_clr,
  input  logic [2:0]       acq_code,
  output logic             go_bit,
  output logic             sample_hold,
  output logic             ev_step,
  output logic             ev_start_conv,
  output logic             ev_done,
  output logic             ev_abort,
  output logic [CNT_W-1:0] step_idx
);

  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(RES_W);
  localparam logic [CNT_W-1:0] REC_LEN   = CNT_W'(REC_TAD);

  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             en_q;
  logic             go_ok;
  logic [CNT_W-1:0] start_len;

  // a request is only taken once the enable has been high for a cycle
  assign go_ok     = go_set & enable & en_q & ~go_clr;
  assign start_len = CNT_W'(acq_tad_count(acq_code));

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    pend_d   = pend_q;
    ev_done  = 1'b0;
    ev_abort = 1'b0;
    if (!enable) begin
      state_d = SEQ_IDLE;
      cnt_d   = '0;
      pend_d  = 1'b0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (go_ok) begin
            state_d = (start_len == '0) ? SEQ_CONV : SEQ_ACQ;
            cnt_d   = start_len;
          end
        end
        SEQ_ACQ: begin
          if (go_clr) begin
            ev_abort = 1'b1;
            state_d  = SEQ_RECOV;
            cnt_d    = REC_LEN;
          end else if (tad_tick) begin
            if (cnt_q == CNT_W'(1)) begin
              state_d = SEQ_CONV;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q - CNT_W'(1);
            end
          end
        end
        SEQ_CONV: begin
          if (go_clr) begin
            ev_abort = 1'b1;
            state_d  = SEQ_RECOV;
            cnt_d    = REC_LEN;
          end else if (tad_tick) begin
            if (cnt_q == LAST_STEP) begin
              ev_done = 1'b1;
              state_d = SEQ_RECOV;
              cnt_d   = REC_LEN;
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end
        end
        default: begin
          if (go_clr)     pend_d = 1'b0;
          else if (go_ok) pend_d = 1'b1;
          if (tad_tick) begin
            if (cnt_q == CNT_W'(1)) begin
              if (pend_d) begin
                state_d = (start_len == '0) ? SEQ_CONV : SEQ_ACQ;
                cnt_d   = start_len;
                pend_d  = 1'b0;
              end else begin
                state_d = SEQ_IDLE;
                cnt_d   = '0;
              end
            end else begin
              cnt_d = cnt_q - CNT_W'(1);
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
      en_q    <= enable;
    end
  end

  assign ev_step       = enable & (state_q == SEQ_CONV) & tad_tick & ~go_clr;
  assign ev_start_conv = (state_d == SEQ_CONV) & (state_q != SEQ_CONV);
  assign step_idx      = cnt_q;
  assign go_bit        = (state_q == SEQ_ACQ) | (state_q == SEQ_CONV) | pend_q;
  assign sample_hold   = (state_q != SEQ_CONV);

  // R6: GO reads low right after a completion
  p_go_drop_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> !go_bit);

  // R8: abort reconnects the capacitor and drops GO
  p_abort_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (sample_hold && !go_bit));

  // R9: the recovery gap only ends on a tick
  p_recov_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && state_q == SEQ_RECOV && !tad_tick) |=> (state_q == SEQ_RECOV));

  // R11: disabled sequencer is idle
  p_idle_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!go_bit && sample_hold));

  // R4: conversion step counter never passes the last bit
  p_step_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_CONV) |-> (cnt_q <= LAST_STEP));

endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
  parameter int RES_W = 10,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_start_conv,
  input  logic             ev_step,
  input  logic [CNT_W-1:0] step_idx,
  input  logic             cmp_in,
  output logic [RES_W-1:0] trial,
  output logic [RES_W-1:0] final_code
);

  // step idx resolves bit RES_W-idx with the comparator and sets the bit below it
  function automatic logic [RES_W-1:0] trial_next(input logic [RES_W-1:0] code,
                                                  input int idx, input logic cmp);
    logic [RES_W-1:0] r;
    int b;
    r = code;
    b = RES_W - idx;
    for (int i = 0; i < RES_W; i++) begin
      if (i == b)     r[i] = cmp;
      if (i == b - 1) r[i] = 1'b1;
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             trial <= '0;
    else if (ev_start_conv) trial <= '0;
    else if (ev_step)       trial <= trial_next(trial, int'(step_idx), cmp_in);
  end

  assign final_code = trial_next(trial, RES_W, cmp_in);

  // R5: first conversion tick raises only the top trial bit
  p_first_trial_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_step && step_idx == '0) |=> (trial == RES_W'(1) << (RES_W - 1)));

  // R5: the trial register starts every conversion from zero
  p_trial_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start_conv |=> (trial == '0));

endmodule

// File: rtl/sar_result_regs.sv
module sar_result_regs #(
  parameter int RES_W = 10,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_done,
  input  logic             ev_abort,
  input  logic [RES_W-1:0] final_code,
  input  logic             left_just,
  input  logic             res_wr,
  input  logic [REG_W-1:0] wr_hi,
  input  logic [REG_W-1:0] wr_lo,
  input  logic             flag_clr,
  output logic [REG_W-1:0] res_hi,
  output logic [REG_W-1:0] res_lo,
  output logic             done_flag
);

  localparam int PAIR_W = 2 * REG_W;
  localparam int PAD    = PAIR_W - RES_W;

  function automatic logic [PAIR_W-1:0] pack_result(input logic [RES_W-1:0] r,
                                                    input logic lj);
    logic [PAIR_W-1:0] w;
    w = PAIR_W'(r);
    if (lj) w = w << PAD;
    return w;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_hi <= '0;
      res_lo <= '0;
    end else if (ev_done) begin
      {res_hi, res_lo} <= pack_result(final_code, left_just);
    end else if (res_wr) begin
      res_hi <= wr_hi;
      res_lo <= wr_lo;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done_flag <= 1'b0;
    else if (ev_done)  done_flag <= 1'b1;
    else if (flag_clr) done_flag <= 1'b0;
  end

  // R10: completion raises the flag even against a clear strobe
  p_flag_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> done_flag);

  // R10: flag only falls by the clear strobe
  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !flag_clr) |=> done_flag);

  // R8: an abort leaves the result pair alone
  p_keep_on_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_abort && !res_wr) |=> ($stable(res_hi) && $stable(res_lo)));

  // R12: a software write lands when no completion competes
  p_sw_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (res_wr && !ev_done) |=> (res_hi == $past(wr_hi) && res_lo == $past(wr_lo)));

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_seq_pkg::*;
#(
  parameter int RES_W   = 10,
  parameter int REG_W   = 8,
  parameter int REC_TAD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tad_tick,
  input  logic             go_set,
  input  logic             go_clr,
  input  logic [2:0]       acq_code,
  input  logic             left_just,
  input  logic             flag_clr,
  input  logic             res_wr,
  input  logic [REG_W-1:0] res_wr_hi,
  input  logic [REG_W-1:0] res_wr_lo,
  input  logic             cmp_in,
  output logic             go_bit,
  output logic             sample_hold,
  output logic [RES_W-1:0] dac_code,
  output logic [REG_W-1:0] res_hi,
  output logic [REG_W-1:0] res_lo,
  output logic             done_flag
);

  localparam int CNT_MAX_A = (int'(ACQ_TAD_MAX) > RES_W) ? int'(ACQ_TAD_MAX) : RES_W;
  localparam int CNT_MAX   = (CNT_MAX_A > REC_TAD) ? CNT_MAX_A : REC_TAD;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);

  logic             ev_step, ev_start_conv, ev_done, ev_abort;
  logic [CNT_W-1:0] step_idx;
  logic [RES_W-1:0] final_code;

  sar_seq_ctrl #(.RES_W(RES_W), .REC_TAD(REC_TAD), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tad_tick(tad_tick),
    .go_set(go_set), .go_clr(go_clr), .acq_code(acq_code),
    .go_bit(go_bit), .sample_hold(sample_hold), .ev_step(ev_step),
    .ev_start_conv(ev_start_conv), .ev_done(ev_done), .ev_abort(ev_abort),
    .step_idx(step_idx)
  );

  sar_approx_reg #(.RES_W(RES_W), .CNT_W(CNT_W)) u_sar (
    .clk(clk), .rst_n(rst_n), .ev_start_conv(ev_start_conv), .ev_step(ev_step),
    .step_idx(step_idx), .cmp_in(cmp_in), .trial(dac_code), .final_code(final_code)
  );

  sar_result_regs #(.RES_W(RES_W), .REG_W(REG_W)) u_res (
    .clk(clk), .rst_n(rst_n), .ev_done(ev_done), .ev_abort(ev_abort),
    .final_code(final_code), .left_just(left_just), .res_wr(res_wr),
    .wr_hi(res_wr_hi), .wr_lo(res_wr_lo), .flag_clr(flag_clr),
    .res_hi(res_hi), .res_lo(res_lo), .done_flag(done_flag)
  );

endmodule

// File: tb/tb_sar_conv_seq.sv
module tb_sar_conv_seq;
  localparam int CLK_PERIOD = 10;
  localparam int RES_W = 10;

  logic clk, rst_n, enable, tad_tick, go_set, go_clr, left_just, flag_clr, res_wr, cmp_in;
  logic [2:0] acq_code;
  logic [7:0] res_wr_hi, res_wr_lo, res_hi, res_lo;
  logic go_bit, sample_hold, done_flag;
  logic [RES_W-1:0] dac_code;

  int vin;
  assign cmp_in = (vin >= int'(dac_code));

  sar_conv_seq dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tad_tick(tad_tick), .go_set(go_set),
    .go_clr(go_clr), .acq_code(acq_code), .left_just(left_just), .flag_clr(flag_clr),
    .res_wr(res_wr), .res_wr_hi(res_wr_hi), .res_wr_lo(res_wr_lo), .cmp_in(cmp_in),
    .go_bit(go_bit), .sample_hold(sample_hold), .dac_code(dac_code),
    .res_hi(res_hi), .res_lo(res_lo), .done_flag(done_flag)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // reference model state: phase 0 idle, 1 acquire, 2 convert, 3 recover
  int m_ph, m_cnt, m_bit, m_trial, m_hi, m_lo;
  bit m_pend, m_flag, m_en_prev;
  int tc, checks, errors;
  int acq_tbl[8] = '{0, 2, 4, 6, 8, 12, 16, 20};

  function automatic int acq_len(int code);
    return (code < 4) ? code * 2 : (code - 2) * 4;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_start();
    int n;
    n = acq_len(int'(acq_code));
    if (n == 0) begin m_ph = 2; m_trial = 0; m_bit = RES_W; end
    else begin m_ph = 1; m_cnt = n; end
  endtask

  task automatic model_edge();
    bit ok, fin, cmp;
    int w;
    cmp = (vin >= m_trial);
    ok  = go_set && enable && m_en_prev && !go_clr;
    fin = 0;
    if (!enable) begin
      m_ph = 0; m_pend = 0;
    end else if (m_ph == 0) begin
      if (ok) model_start();
    end else if (m_ph == 1) begin
      if (go_clr) begin m_ph = 3; m_cnt = 2; end
      else if (tad_tick) begin
        m_cnt--;
        if (m_cnt == 0) begin m_ph = 2; m_trial = 0; m_bit = RES_W; end
      end
    end else if (m_ph == 2) begin
      if (go_clr) begin m_ph = 3; m_cnt = 2; end
      else if (tad_tick) begin
        if (m_bit < RES_W && !cmp) m_trial &= ~(1 << m_bit);
        if (m_bit == 0) begin fin = 1; m_ph = 3; m_cnt = 2; end
        else begin m_bit--; m_trial |= (1 << m_bit); end
      end
    end else begin
      if (go_clr) m_pend = 0;
      else if (ok) m_pend = 1;
      if (tad_tick) begin
        m_cnt--;
        if (m_cnt == 0) begin
          if (m_pend) begin m_pend = 0; model_start(); end
          else m_ph = 0;
        end
      end
    end
    if (fin) begin
      w = left_just ? (m_trial << (16 - RES_W)) : m_trial;
      m_hi = (w >> 8) & 255; m_lo = w & 255; m_flag = 1;
    end else begin
      if (res_wr) begin m_hi = int'(res_wr_hi); m_lo = int'(res_wr_lo); end
      if (flag_clr) m_flag = 0;
    end
    m_en_prev = enable;
  endtask

  task automatic compare();
    chk("R1 go_bit", int'(go_bit), int'((m_ph == 1) || (m_ph == 2) || m_pend));
    chk("R3 sample_hold", int'(sample_hold), int'(m_ph != 2));
    chk("R5 dac_code", int'(dac_code), m_trial);
    chk("R6 res_hi", int'(res_hi), m_hi);
    chk("R6 res_lo", int'(res_lo), m_lo);
    chk("R10 done_flag", int'(done_flag), int'(m_flag));
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    if (rst_n) model_edge();
    compare();
    tc = (tc + 1) % 3;
    tad_tick = (tc == 0);
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 3000 && m_ph != 0; g++) step();
  endtask

  task automatic run_conv(int code, bit lj, int v);
    int at, ct, e;
    vin = v; acq_code = 3'(code); left_just = lj;
    go_set = 1; step(); go_set = 0;
    if (code == 0) chk("R2 hold after go", int'(sample_hold), 0);
    else chk("R3 hold after go", int'(sample_hold), 1);
    at = 0; ct = 0;
    for (int g = 0; g < 3000 && (m_ph == 1 || m_ph == 2); g++) begin
      if (tad_tick) begin if (sample_hold) at++; else ct++; end
      step();
    end
    chk("R3 acquisition ticks", at, acq_tbl[code]);
    chk("R4 conversion ticks", ct, 11);
    chk("R6 go low at done", int'(go_bit), 0);
    chk("R6 flag at done", int'(done_flag), 1);
    chk("R6 reconnected", int'(sample_hold), 1);
    e = lj ? (v << 6) : v;
    chk("R7 res_hi", int'(res_hi), (e >> 8) & 255);
    chk("R7 res_lo", int'(res_lo), e & 255);
    wait_idle();
    chk("R10 flag sticky", int'(done_flag), 1);
  endtask

  task automatic to_last_tick(int code, int v);
    vin = v; acq_code = 3'(code); left_just = 0;
    go_set = 1; step(); go_set = 0;
    for (int g = 0; g < 3000 && !(m_ph == 2 && m_bit == 0 && tad_tick); g++) step();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int vals[8] = '{677, 1023, 0, 512, 341, 1, 700, 999};
    int sh, sl, rt;
    checks = 0; errors = 0; tc = 0;
    m_ph = 0; m_cnt = 0; m_bit = 0; m_trial = 0; m_hi = 0; m_lo = 0;
    m_pend = 0; m_flag = 0; m_en_prev = 0;
    rst_n = 0; enable = 0; tad_tick = 0; go_set = 0; go_clr = 0; left_just = 0;
    flag_clr = 0; res_wr = 0; res_wr_hi = 0; res_wr_lo = 0; acq_code = 0; vin = 0;
    step(); step(); step();
    rst_n = 1;
    chk("R1 reset go", int'(go_bit), 0);
    chk("R1 reset hold", int'(sample_hold), 1);
    chk("R1 reset dac", int'(dac_code), 0);
    chk("R1 reset result", int'({res_hi, res_lo}), 0);
    chk("R1 reset flag", int'(done_flag), 0);

    // R11: request in the enabling cycle is dropped
    enable = 1; go_set = 1; step(); go_set = 0; step();
    chk("R11 go on enable edge", int'(go_bit), 0);

    for (int c = 0; c < 8; c++) run_conv(c, c[0], vals[c]);

    flag_clr = 1; step(); flag_clr = 0;
    chk("R10 flag cleared", int'(done_flag), 0);

    // R8: abort mid-conversion
    sh = int'(res_hi); sl = int'(res_lo);
    vin = 100; acq_code = 0; go_set = 1; step(); go_set = 0;
    for (int g = 0; g < 3000 && !(m_ph == 2 && m_bit < 5); g++) step();
    go_clr = 1; step(); go_clr = 0;
    chk("R8 go after abort", int'(go_bit), 0);
    chk("R8 res kept", int'({res_hi, res_lo}), (sh << 8) | sl);
    chk("R8 flag kept", int'(done_flag), 0);
    wait_idle();

    // R8: abort during acquisition
    acq_code = 7; go_set = 1; step(); go_set = 0;
    for (int k = 0; k < 5; k++) step();
    go_clr = 1; step(); go_clr = 0;
    chk("R8 abort in acquisition", int'(go_bit), 0);
    chk("R8 res kept acq", int'({res_hi, res_lo}), (sh << 8) | sl);
    wait_idle();

    // R9: request during recovery is held for 2 ticks
    to_last_tick(0, 300); step();
    go_set = 1; rt = 0;
    for (int g = 0; g < 3000 && sample_hold; g++) begin
      if (tad_tick) rt++;
      step(); go_set = 0;
      if (g == 0) chk("R9 held request go", int'(go_bit), 1);
    end
    chk("R9 recovery ticks", rt, 2);
    for (int g = 0; g < 3000 && m_ph == 2; g++) step();
    chk("R9 held conversion result", int'({res_hi, res_lo}), 300);
    wait_idle();

    // R10/R12: completion against flag clear and software write
    flag_clr = 1; step(); flag_clr = 0;
    to_last_tick(0, 55);
    flag_clr = 1; res_wr = 1; res_wr_hi = 8'h77; res_wr_lo = 8'h11; step();
    flag_clr = 0; res_wr = 0;
    chk("R10 set beats clear", int'(done_flag), 1);
    chk("R12 completion beats write", int'({res_hi, res_lo}), 55);
    wait_idle();

    // R8: abort on the completing tick
    to_last_tick(0, 900);
    go_clr = 1; step(); go_clr = 0;
    chk("R8 abort beats completion", int'({res_hi, res_lo}), 55);
    chk("R8 go dropped", int'(go_bit), 0);
    wait_idle();

    // R12: software write, then abort keeps it
    res_wr = 1; res_wr_hi = 8'hA5; res_wr_lo = 8'h3C; step(); res_wr = 0;
    chk("R12 write hi", int'(res_hi), 165);
    chk("R12 write lo", int'(res_lo), 60);
    to_last_tick(0, 12);
    go_clr = 1; step(); go_clr = 0;
    chk("R8 keeps written value", int'({res_hi, res_lo}), 16'hA53C);
    wait_idle();

    // R11: disable during conversion
    vin = 444; acq_code = 0; go_set = 1; step(); go_set = 0; step();
    enable = 0; step();
    chk("R11 go when disabled", int'(go_bit), 0);
    chk("R11 hold when disabled", int'(sample_hold), 1);
    enable = 1; go_set = 1; step(); go_set = 0; step();
    chk("R11 go ignored on re-enable", int'(go_bit), 0);
    run_conv(2, 0, 444);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule